// File: doc/BRIEF.md
# BCD Calendar Clock with Hour/Minute Alarm

This block is the timekeeping core of a real-time clock. It holds year, month, day, weekday, hour, minute and second as packed BCD bytes. A one-second tick input advances the time, with full carry through the calendar, including month lengths and leap years. A small parallel register port reads and writes single bytes. Every access is one strobe carrying a register select and a byte index, so a host walks through a multi-byte register as a burst of strobes.

Two status bytes hold the flags and the configuration. A three-byte alarm compares weekday, hour and minute at each minute boundary. The alarm sets a flag and raises an interrupt output, and a read of the first status byte acknowledges it. The serial bus that would normally sit in front of the port is not part of this block, and neither is the oscillator that produces the tick.

Top module: `rtc_core`

## Requirements
- R1: After the synchronous reset, the time reads year 00, month 01, day 01, weekday 00, hour 00, minute 00, second 00. Status 1 reads 0x80 (power-on flag only) while the low-supply input is low. Status 2 reads 0x00, `irq` is 0 and `bus_rdata` is 0x00.
- R2: Register selects are: 0 for status 1, 1 for status 2, 2 for the time register and 4 for the alarm register. Any other select reads 0x00 and ignores writes. Within the time register, byte indices 0 to 6 are year, month, day, weekday, hour, minute and second. `bus_rdata` shows the addressed byte on the cycle after a `bus_rd` strobe and holds it until the next read.
- R3: A tick advances the seconds. The carry runs from 59 seconds into the minutes, from 59 minutes into the hours, and from hour 23 into day and weekday, so 23:59:59 becomes 00:00:00. The weekday wraps from 06 to 00. A time write in the same cycle as a tick takes priority, and that tick is lost.
- R4: The day wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days, month 02 has 29 days when the year is a multiple of 4 and 28 otherwise, and all other months have 31. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R5: The hour byte carries a PM flag in bit 6, set for the 24-hour values 12 to 23. When status 1 bit 1 is set, bits 5:0 hold the hour 00 to 23. When it is clear, bits 5:0 hold the hour modulo 12. Hour writes are read the same way: in 12-hour mode the PM bit adds 12, and in 24-hour mode the PM bit is ignored.
- R6: Status 1 has this layout. Bit 7 is the power-on flag. Bit 6 is the low-supply input, registered one cycle. Bit 5 is the second interrupt flag and always reads 0. Bit 4 is the alarm flag. Bits 3:2 are scratch bits. Bit 1 selects 24-hour mode. Bit 0 always reads 0. A write changes only bits 3:1.
- R7: Writing status 1 with bit 0 set restores the reset values of R1. This clears the power-on flag, status 2, the alarm bytes and the alarm flag.
- R8: A read of status 1 returns the alarm flag and then clears it, which also drops `irq`. If an alarm match lands in the same cycle as the read, the read returns 0 in bit 4 and the flag stays set.
- R9: Status 2 is an 8-bit read/write byte. Its bit 2 is the alarm enable, which gates both the alarm register access and alarm matching.
- R10: The alarm register has three bytes. Byte 0 is the weekday, with enable in bit 7 and the value in bits 2:0. Byte 1 is the hour, with enable in bit 7, PM in bit 6 and the BCD hour in bits 5:0. Byte 2 is the minute, with enable in bit 7 and the BCD minute in bits 6:0. While status 2 bit 2 is clear, alarm writes are ignored and alarm reads return 0x00.
- R11: A match requires status 2 bit 2 to be set and every enabled alarm field to equal the current time. The hour is compared as a full byte, including PM, in its displayed form. The comparison happens when a tick makes the seconds 00, and the alarm flag and `irq` go high one cycle after that tick's edge. With no field enabled, the alarm fires every minute.
- R12: `irq` follows the alarm flag and stays high across further ticks until a status 1 read or a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| low_batt | input | 1 | Low-supply indication |
| bus_sel | input | 3 | Register select |
| bus_idx | input | 3 | Byte index within the register |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The calendar is tried with start times chosen right before each carry: the end of a minute and of a day, February in a leap year and a common year, a 30-day month, and the end of the century. Each one exercises a different day-limit branch. The hour byte is written and read in both display modes, which separates the stored 24-hour value from its 12-hour form and its PM flag. The alarm is tried with these patterns:
- a full match
- a PM-bit mismatch
- a minute mismatch
- an enabled weekday
- alarm enable clear
- a status read landing on the match cycle

Together they distinguish the field masking, the enable gating and the set-over-clear priority. A behavioural model runs beside the design and checks `bus_rdata` and `irq` on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ALM_BYTES = 3;

  localparam int SEL_ST1  = 0;
  localparam int SEL_ST2  = 1;
  localparam int SEL_TIME = 2;
  localparam int SEL_ALM  = 4;

  localparam int IX_YEAR  = 0;
  localparam int IX_MONTH = 1;
  localparam int IX_DAY   = 2;
  localparam int IX_WDAY  = 3;
  localparam int IX_HOUR  = 4;
  localparam int IX_MIN   = 5;
  localparam int IX_SEC   = 6;

  localparam int AL_WDAY = 0;
  localparam int AL_HOUR = 1;
  localparam int AL_MIN  = 2;

  localparam int ST1_RST_BIT = 0;
  localparam int ST2_AE_BIT  = 2;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] == 4'd9) return {b[7:4] + 4'd1, 4'd0};
    else                return {b[7:4], b[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [3:0] t;
    logic [3:0] o;
    t = 4'(v / 7'd10);
    o = 4'(v % 7'd10);
    return {t, o};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] r;
    r = {yr[4], 1'b0} + yr[1:0];
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon,
                                               input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_to_bus(input logic [7:0] h24,
                                             input logic mode24);
    logic [6:0] bin;
    logic       pm;
    logic [6:0] v;
    bin = bcd2bin(h24);
    pm  = (bin >= 7'd12);
    v   = (mode24 || !pm) ? bin : bin - 7'd12;
    return (bin2bcd(v) & 8'h3F) | {1'b0, pm, 6'd0};
  endfunction

  function automatic logic [7:0] hour_from_bus(input logic [7:0] b,
                                               input logic mode24);
    logic [6:0] bin;
    bin = bcd2bin({2'b00, b[5:0]});
    if (!mode24 && b[6]) bin = bin + 7'd12;
    return bin2bcd(bin);
  endfunction

  function automatic logic [7:0] field_mask(input int i);
    return (i == AL_WDAY) ? 8'h07 : 8'h7F;
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int         IDX_W     = 3,
  parameter logic [7:0] DEF_YEAR  = 8'h00,
  parameter logic [7:0] DEF_MONTH = 8'h01,
  parameter logic [7:0] DEF_DAY   = 8'h01,
  parameter logic [7:0] DEF_WDAY  = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_def,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             mode24,
  output rtc_time_t        time_o,
  output logic [7:0]       hour_bus_o,
  output logic             wrap_o
);

  rtc_time_t cur_q;
  rtc_time_t adv;
  rtc_time_t def_t;
  logic      wrap_q;
  logic      tick_go;
  logic [7:0] mdays;

  always_comb begin
    def_t       = '0;
    def_t.year  = DEF_YEAR;
    def_t.month = DEF_MONTH;
    def_t.day   = DEF_DAY;
    def_t.wday  = DEF_WDAY;
  end

  assign tick_go = tick & ~wr_en;
  assign mdays   = days_in_month(cur_q.month, cur_q.year);

  // carry chain through the calendar, all fields BCD
  always_comb begin
    adv = cur_q;
    if (cur_q.sec == 8'h59) begin
      adv.sec = 8'h00;
      if (cur_q.min == 8'h59) begin
        adv.min = 8'h00;
        if (cur_q.hour == 8'h23) begin
          adv.hour = 8'h00;
          adv.wday = (cur_q.wday == 8'h06) ? 8'h00 : bcd_inc(cur_q.wday);
          if (cur_q.day == mdays) begin
            adv.day = 8'h01;
            if (cur_q.month == 8'h12) begin
              adv.month = 8'h01;
              adv.year  = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
            end else begin
              adv.month = bcd_inc(cur_q.month);
            end
          end else begin
            adv.day = bcd_inc(cur_q.day);
          end
        end else begin
          adv.hour = bcd_inc(cur_q.hour);
        end
      end else begin
        adv.min = bcd_inc(cur_q.min);
      end
    end else begin
      adv.sec = bcd_inc(cur_q.sec);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load_def) begin
      cur_q  <= def_t;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= tick_go && (cur_q.sec == 8'h59);
      if (wr_en) begin
        case (int'(wr_idx))
          IX_YEAR:  cur_q.year  <= wr_byte;
          IX_MONTH: cur_q.month <= wr_byte;
          IX_DAY:   cur_q.day   <= wr_byte;
          IX_WDAY:  cur_q.wday  <= wr_byte;
          IX_HOUR:  cur_q.hour  <= hour_from_bus(wr_byte, mode24);
          IX_MIN:   cur_q.min   <= wr_byte;
          IX_SEC:   cur_q.sec   <= wr_byte;
          default:  ;
        endcase
      end else if (tick) begin
        cur_q <= adv;
      end
    end
  end

  assign time_o     = cur_q;
  assign hour_bus_o = hour_to_bus(cur_q.hour, mode24);
  assign wrap_o     = wrap_q;

  // R3
  sec_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !load_def && cur_q.sec == 8'h59) |=> (cur_q.sec == 8'h00));

  // R3
  min_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !load_def && cur_q.sec != 8'h59) |=> $stable(cur_q.min));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en && !load_def) |=> $stable(cur_q));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             access_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wr_byte,
  output logic [7:0]       rd_byte,
  input  logic             wrap,
  input  logic [7:0]       cur_wday,
  input  logic [7:0]       cur_hour,
  input  logic [7:0]       cur_min,
  output logic             hit_o
);

  localparam int AIW = $clog2(ALM_BYTES);

  logic [ALM_BYTES-1:0][7:0] alm_q;
  logic [ALM_BYTES-1:0][7:0] cur_b;
  logic [ALM_BYTES-1:0]      fld_ok;
  logic                      in_rng;
  logic [AIW-1:0]            aidx;

  assign in_rng = (int'(idx) < ALM_BYTES);
  assign aidx   = idx[AIW-1:0];

  always_comb begin
    cur_b          = '0;
    cur_b[AL_WDAY] = cur_wday;
    cur_b[AL_HOUR] = cur_hour;
    cur_b[AL_MIN]  = cur_min;
  end

  for (genvar g = 0; g < ALM_BYTES; g++) begin : g_fld
    localparam logic [7:0] MSK = field_mask(g);
    assign fld_ok[g] = !alm_q[g][7] || ((alm_q[g] & MSK) == (cur_b[g] & MSK));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      alm_q <= '0;
    end else if (wr_en && access_en && in_rng) begin
      alm_q[aidx] <= wr_byte;
    end
  end

  assign rd_byte = (access_en && in_rng) ? alm_q[aidx] : 8'h00;
  assign hit_o   = wrap && access_en && (&fld_ok);

  // R10
  locked_alm_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !access_en && !clear) |=> $stable(alm_q));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int         SEL_W     = 3,
  parameter int         IDX_W     = 3,
  parameter logic [7:0] DEF_YEAR  = 8'h00,
  parameter logic [7:0] DEF_MONTH = 8'h01,
  parameter logic [7:0] DEF_DAY   = 8'h01,
  parameter logic [7:0] DEF_WDAY  = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1hz,
  input  logic             low_batt,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq
);

  logic       poc_q, bld_q, int1_q, m24_q;
  logic [1:0] scr_q;
  logic [7:0] st2_q;
  logic [7:0] rd_mux, rdata_q;

  logic st1_wr, st1_rd, st2_wr, time_wr, alm_wr, soft_rst;
  logic alm_hit, cal_wrap;
  logic [7:0] hour_bus, alm_rd;
  rtc_time_t  cur_t;

  assign st1_wr   = bus_wr && (int'(bus_sel) == SEL_ST1);
  assign st1_rd   = bus_rd && (int'(bus_sel) == SEL_ST1);
  assign st2_wr   = bus_wr && (int'(bus_sel) == SEL_ST2);
  assign time_wr  = bus_wr && (int'(bus_sel) == SEL_TIME);
  assign alm_wr   = bus_wr && (int'(bus_sel) == SEL_ALM);
  assign soft_rst = st1_wr && bus_wdata[ST1_RST_BIT];

  rtc_calendar #(
    .IDX_W(IDX_W), .DEF_YEAR(DEF_YEAR), .DEF_MONTH(DEF_MONTH),
    .DEF_DAY(DEF_DAY), .DEF_WDAY(DEF_WDAY)
  ) cal_i (
    .clk(clk), .rst(rst), .load_def(soft_rst), .tick(tick_1hz),
    .wr_en(time_wr), .wr_idx(bus_idx), .wr_byte(bus_wdata), .mode24(m24_q),
    .time_o(cur_t), .hour_bus_o(hour_bus), .wrap_o(cal_wrap)
  );

  rtc_alarm #(.IDX_W(IDX_W)) alm_i (
    .clk(clk), .rst(rst), .clear(soft_rst), .access_en(st2_q[ST2_AE_BIT]),
    .wr_en(alm_wr), .idx(bus_idx), .wr_byte(bus_wdata), .rd_byte(alm_rd),
    .wrap(cal_wrap), .cur_wday(cur_t.wday), .cur_hour(hour_bus),
    .cur_min(cur_t.min), .hit_o(alm_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      poc_q  <= 1'b1;
      bld_q  <= 1'b0;
      int1_q <= 1'b0;
      scr_q  <= 2'b00;
      m24_q  <= 1'b0;
      st2_q  <= 8'h00;
    end else begin
      bld_q <= low_batt;
      if (soft_rst) begin
        poc_q  <= 1'b0;
        int1_q <= 1'b0;
        scr_q  <= 2'b00;
        m24_q  <= 1'b0;
        st2_q  <= 8'h00;
      end else begin
        if (st1_wr) {scr_q, m24_q} <= bus_wdata[3:1];
        if (st2_wr) st2_q <= bus_wdata;
        if (alm_hit)     int1_q <= 1'b1;
        else if (st1_rd) int1_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (int'(bus_sel))
      SEL_ST1:  rd_mux = {poc_q, bld_q, 1'b0, int1_q, scr_q, m24_q, 1'b0};
      SEL_ST2:  rd_mux = st2_q;
      SEL_TIME: begin
        case (int'(bus_idx))
          IX_YEAR:  rd_mux = cur_t.year;
          IX_MONTH: rd_mux = cur_t.month;
          IX_DAY:   rd_mux = cur_t.day;
          IX_WDAY:  rd_mux = cur_t.wday;
          IX_HOUR:  rd_mux = hour_bus;
          IX_MIN:   rd_mux = cur_t.min;
          IX_SEC:   rd_mux = cur_t.sec;
          default:  rd_mux = 8'h00;
        endcase
      end
      SEL_ALM:  rd_mux = alm_rd;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = int1_q;

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(int1_q) |-> $past(cal_wrap && st2_q[ST2_AE_BIT]));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st1_rd && !alm_hit) |=> !int1_q);

  // R7
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!poc_q && st2_q == 8'h00 && !int1_q));

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (int1_q && !st1_rd && !soft_rst) |=> int1_q);

endmodule

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       low_batt = 1'b0;
  logic [2:0] bus_sel = '0;
  logic [2:0] bus_idx = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rtc_core dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .low_batt(low_batt),
    .bus_sel(bus_sel), .bus_idx(bus_idx), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- reference model ----------------
  int m_yr, m_mo, m_dy, m_wd, m_hr, m_mi, m_se;
  bit m_poc, m_bld, m_int1, m_m24, m_pend;
  bit [1:0]   m_scr;
  logic [7:0] m_st2;
  logic [7:0] m_alm [3];
  logic [7:0] m_rdata;

  function automatic logic [7:0] tobcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hbyte(int h, bit m24);
    int v;
    v = m24 ? h : h % 12;
    return tobcd(v) | ((h >= 12) ? 8'h40 : 8'h00);
  endfunction

  task automatic m_defaults();
    m_yr = 0; m_mo = 1; m_dy = 1; m_wd = 0; m_hr = 0; m_mi = 0; m_se = 0;
    m_scr = 0; m_m24 = 0; m_st2 = 0; m_int1 = 0; m_pend = 0;
    foreach (m_alm[i]) m_alm[i] = 8'h00;
  endtask

  function automatic logic [7:0] m_read(int sel, int idx);
    case (sel)
      0: return {m_poc, m_bld, 1'b0, m_int1, m_scr, m_m24, 1'b0};
      1: return m_st2;
      2: case (idx)
           0: return tobcd(m_yr);
           1: return tobcd(m_mo);
           2: return tobcd(m_dy);
           3: return tobcd(m_wd);
           4: return hbyte(m_hr, m_m24);
           5: return tobcd(m_mi);
           6: return tobcd(m_se);
           default: return 8'h00;
         endcase
      4: return (m_st2[2] && idx < 3) ? m_alm[idx] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    bit hit, np, twr;
    logic [7:0] hb;
    if (rst) begin
      m_defaults();
      m_poc = 1; m_bld = 0; m_rdata = 8'h00;
    end else begin
      hb  = hbyte(m_hr, m_m24);
      hit = m_pend && m_st2[2]
            && (!m_alm[0][7] || m_alm[0][2:0] == 3'(m_wd))
            && (!m_alm[1][7] || m_alm[1][6:0] == hb[6:0])
            && (!m_alm[2][7] || m_alm[2][6:0] == tobcd(m_mi)[6:0]);
      twr = bus_wr && int'(bus_sel) == 2;
      np  = tick_1hz && !twr && m_se == 59;
      if (bus_rd) m_rdata = m_read(int'(bus_sel), int'(bus_idx));
      if (hit) m_int1 = 1;
      else if (bus_rd && bus_sel == 3'd0) m_int1 = 0;
      m_bld = low_batt;
      if (bus_wr) begin
        case (int'(bus_sel))
          0: {m_scr, m_m24} = bus_wdata[3:1];
          1: m_st2 = bus_wdata;
          2: case (int'(bus_idx))
               0: m_yr = frombcd(bus_wdata);
               1: m_mo = frombcd(bus_wdata);
               2: m_dy = frombcd(bus_wdata);
               3: m_wd = frombcd(bus_wdata);
               4: m_hr = frombcd({2'b00, bus_wdata[5:0]})
                         + ((!m_m24 && bus_wdata[6]) ? 12 : 0);
               5: m_mi = frombcd(bus_wdata);
               6: m_se = frombcd(bus_wdata);
               default: ;
             endcase
          4: if (m_st2[2] && bus_idx < 3) m_alm[bus_idx] = bus_wdata;
          default: ;
        endcase
      end else if (tick_1hz) begin
        if (m_se == 59) begin
          m_se = 0;
          if (m_mi == 59) begin
            m_mi = 0;
            if (m_hr == 23) begin
              m_hr = 0;
              m_wd = (m_wd == 6) ? 0 : m_wd + 1;
              if (m_dy == mdays(m_mo, m_yr)) begin
                m_dy = 1;
                if (m_mo == 12) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
                else m_mo++;
              end else m_dy++;
            end else m_hr++;
          end else m_mi++;
        end else m_se++;
      end
      m_pend = np;
      if (bus_wr && bus_sel == 3'd0 && bus_wdata[0]) begin
        m_defaults();
        m_poc = 0;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 model rdata", bus_rdata, m_rdata);
      check("R12 model irq", {7'd0, irq}, {7'd0, m_int1});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(int sel, int idx, logic [7:0] d);
    @(negedge clk);
    bus_sel = 3'(sel); bus_idx = 3'(idx); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int sel, int idx, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 3'(sel); bus_idx = 3'(idx); bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
  endtask

  task automatic set_time(logic [7:0] y, mo, d, w, h, mi, s);
    wr(2, 0, y); wr(2, 1, mo); wr(2, 2, d); wr(2, 3, w);
    wr(2, 4, h); wr(2, 5, mi); wr(2, 6, s);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, 0, v); check("R1 status1", v, 8'h80);
    rd(1, 0, v); check("R1 status2", v, 8'h00);
    rd(2, 0, v); check("R1 year", v, 8'h00);
    rd(2, 1, v); check("R1 month", v, 8'h01);
    rd(2, 2, v); check("R1 day", v, 8'h01);
    rd(2, 6, v); check("R1 second", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    // R2 unused select
    rd(3, 0, v); check("R2 unused select", v, 8'h00);
    // R6 layout
    wr(0, 0, 8'h0E);
    rd(0, 0, v); check("R6 writable bits", v, 8'h8E);
    low_batt = 1; idle(2);
    rd(0, 0, v); check("R6 low supply bit", v, 8'hCE);
    low_batt = 0; idle(2);
    wr(0, 0, 8'h02);
    // R3 R4 leap day
    set_time(8'h24, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h58);
    tick(); tick();
    rd(2, 2, v); check("R4 leap Feb 29", v, 8'h29);
    rd(2, 3, v); check("R3 weekday wrap", v, 8'h00);
    rd(2, 4, v); check("R3 hour wrap", v, 8'h00);
    rd(2, 5, v); check("R3 minute wrap", v, 8'h00);
    wr(2, 6, 8'h59); wr(2, 5, 8'h59); wr(2, 4, 8'h23);
    tick();
    rd(2, 1, v); check("R4 leap Feb end month", v, 8'h03);
    rd(2, 2, v); check("R4 leap Feb end day", v, 8'h01);
    set_time(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    rd(2, 1, v); check("R4 common Feb month", v, 8'h03);
    set_time(8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    rd(2, 1, v); check("R4 30-day month", v, 8'h05);
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    tick();
    rd(2, 0, v); check("R4 year wrap", v, 8'h00);
    rd(2, 1, v); check("R4 month wrap", v, 8'h01);
    rd(2, 2, v); check("R4 day wrap", v, 8'h01);
    // R5 hour modes
    wr(0, 0, 8'h00);
    wr(2, 4, 8'h47);
    rd(2, 4, v); check("R5 12h read", v, 8'h47);
    wr(0, 0, 8'h02);
    rd(2, 4, v); check("R5 24h read of 19h", v, 8'h59);
    wr(2, 4, 8'h12);
    rd(2, 4, v); check("R5 noon PM flag", v, 8'h52);
    // R9 R10 alarm access gating
    wr(4, 1, 8'hD3);
    wr(1, 0, 8'h04);
    rd(1, 0, v); check("R9 status2 readback", v, 8'h04);
    rd(4, 1, v); check("R10 locked write ignored", v, 8'h00);
    wr(4, 1, 8'hD3);
    wr(1, 0, 8'h00);
    rd(4, 1, v); check("R10 locked read zero", v, 8'h00);
    wr(1, 0, 8'h04);
    rd(4, 1, v); check("R10 unlocked read", v, 8'hD3);
    wr(4, 2, 8'h85); wr(4, 0, 8'h00);
    // R11 full match
    set_time(8'h24, 8'h05, 8'h01, 8'h03, 8'h13, 8'h04, 8'h58);
    tick(); idle(2);
    check("R11 no early irq", {7'd0, irq}, 8'h00);
    tick(); idle(1);
    check("R11 match irq", {7'd0, irq}, 8'h01);
    tick(); idle(2);
    check("R12 irq holds", {7'd0, irq}, 8'h01);
    rd(0, 0, v); check("R8 status1 shows flag", v, 8'h92);
    idle(1);
    check("R8 irq cleared", {7'd0, irq}, 8'h00);
    // R11 PM mismatch
    wr(4, 1, 8'h93);
    wr(2, 5, 8'h04); wr(2, 6, 8'h59);
    tick(); idle(2);
    check("R11 PM mismatch", {7'd0, irq}, 8'h00);
    // R11 minute mismatch
    wr(4, 1, 8'hD3); wr(4, 2, 8'h86);
    wr(2, 5, 8'h04); wr(2, 6, 8'h59);
    tick(); idle(2);
    check("R11 minute mismatch", {7'd0, irq}, 8'h00);
    // R11 weekday enabled
    wr(4, 0, 8'h83); wr(4, 2, 8'h85);
    wr(2, 5, 8'h04); wr(2, 6, 8'h59);
    tick(); idle(2);
    check("R11 weekday match", {7'd0, irq}, 8'h01);
    rd(0, 0, v);
    // R8 read on the match cycle
    wr(2, 5, 8'h04); wr(2, 6, 8'h59);
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0; bus_sel = 3'd0; bus_idx = 3'd0; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    check("R8 same-cycle read value", bus_rdata, 8'h82);
    check("R8 set wins", {7'd0, irq}, 8'h01);
    rd(0, 0, v);
    // R11 enable clear blocks match
    wr(1, 0, 8'h00);
    wr(2, 5, 8'h04); wr(2, 6, 8'h59);
    tick(); idle(2);
    check("R11 disabled alarm", {7'd0, irq}, 8'h00);
    // R7 soft reset
    wr(1, 0, 8'h04);
    wr(0, 0, 8'h01);
    rd(0, 0, v); check("R7 status1", v, 8'h00);
    rd(1, 0, v); check("R7 status2", v, 8'h00);
    rd(2, 0, v); check("R7 year", v, 8'h00);
    rd(2, 4, v); check("R7 hour", v, 8'h00);
    wr(1, 0, 8'h04);
    rd(4, 1, v); check("R7 alarm cleared", v, 8'h00);
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule